// File: doc/BRIEF.md
# Fractional Baud-Rate Prescaler

This block turns a fast source clock into a one-cycle enable pulse whose average rate is the source rate divided by a non-integer divisor. It is meant to feed the 16x sample clock of a serial receiver and transmitter. When the integer dividers in that path cannot reach a standard bit rate, the fractional divisor supplies the missing precision. A three-bit range code picks a power-of-two band for the divisor. An eight-bit step value places the divisor inside that band.

Inside the block, the divisor is a fixed-point number with seven fractional bits, so one source cycle counts as 128 units. A phase accumulator adds 128 on every enabled cycle. When the sum reaches or passes the divisor, the accumulator emits a pulse and subtracts the divisor. The spacing between pulses therefore alternates between the two integers next to the divisor, and the long-run average matches the divisor exactly. A new range or step value is adopted only when a pulse is emitted, or while the block is idle. Dropping the enable input returns the block to a clean idle state.

Top module: `frac_baud_prescaler`

## Requirements
- R1: While reset is high, and on the first cycle after it, the tick output is low and the phase accumulator is zero, whatever the other inputs are.
- R2: For a range code s from 0 to 6, the divisor D equals 2^(s+1) + step × 2^(s−7) source cycles. Expressed in 1/128-cycle units, this is D = 2^(s+8) + step·2^s. Code 0 therefore covers 2 to 3 127/128 in 1/128 steps, and code 6 covers 128 to 255 1/2 in 1/2 steps.
- R3: Range code 7 gives a divisor of exactly 1, whatever the step value is. The tick is then high on every enabled cycle.
- R4: Count enabled clock edges from 1, starting at the first edge with enable high. The k-th tick is registered at edge ceil(k·D/128), so after edge c the tick count is floor(128·c/D). The tick output is high in the cycle that follows that edge.
- R5: Every interval between consecutive ticks is either floor(D/128) or ceil(D/128) cycles long.
- R6: Any run of 128 consecutive tick periods, counted from enable, spans exactly D/128 × 128 = D (in 1/128 units) source cycles.
- R7: On a cycle with enable low, no tick is produced and the accumulator clears. After enable is raised again, the tick pattern restarts from edge 1 as in R4.
- R8: A change to the range code or step value while enabled does not affect the period in progress. The block samples the new divisor on the edge that registers a tick, and that divisor governs the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the block idle and clears the phase |
| range_sel | input | 3 | Range code: 0..6 select power-of-two bands, 7 selects divide-by-one |
| step_val | input | 8 | Fractional position within the selected band |
| tick | output | 1 | One-cycle rate enable |

## Verification
The divisor update and the tick emission happen on the same clock edge, because the edge that registers a tick also samples a fresh divisor. The bench provokes this by changing the range code in the middle of a long period. It then checks that the old period still ends on its original cycle and that the very next interval follows the new divisor. The same coincidence at its extreme is divide-by-one, where every edge is both a tick and a reload. The bench sweeps code 7 and judges that the tick stays high on every enabled cycle.

// File: rtl/fbp_pkg.sv
`timescale 1ns/1ps
package fbp_pkg;

    localparam int SEL_W  = 3;
    localparam int STEP_W = 8;
    localparam int FRAC_W = 7;

    typedef enum logic [SEL_W-1:0] {
        RANGE_2     = 3'd0,
        RANGE_4     = 3'd1,
        RANGE_8     = 3'd2,
        RANGE_16    = 3'd3,
        RANGE_32    = 3'd4,
        RANGE_64    = 3'd5,
        RANGE_128   = 3'd6,
        RANGE_UNITY = 3'd7
    } range_code_e;

    // Width of the fixed-point divisor: largest band base plus its steps.
    function automatic int div_width(input int sel_w, input int step_w);
        return step_w + (1 << sel_w) - 1;
    endfunction

endpackage

// File: rtl/fbp_divisor_decode.sv
`timescale 1ns/1ps
module fbp_divisor_decode #(
    parameter int SEL_W  = fbp_pkg::SEL_W,
    parameter int STEP_W = fbp_pkg::STEP_W,
    parameter int FRAC_W = fbp_pkg::FRAC_W,
    parameter int DIV_W  = fbp_pkg::div_width(SEL_W, STEP_W)
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [STEP_W-1:0] step,
    output logic [DIV_W-1:0]  divisor
);
    localparam int NCODES = 1 << SEL_W;

    logic [DIV_W-1:0] cand [NCODES];
    logic [DIV_W-1:0] step_ext;

    assign step_ext = {{(DIV_W-STEP_W){1'b0}}, step};

    // Bands: base doubles per code, step weight doubles with it.
    for (genvar g = 0; g < NCODES - 1; g++) begin : g_band
        localparam logic [DIV_W-1:0] BASE = DIV_W'(1) << (g + STEP_W);
        assign cand[g] = BASE + (step_ext << g);
    end

    // Top code: exactly one source cycle.
    assign cand[NCODES-1] = DIV_W'(1) << FRAC_W;

    assign divisor = cand[sel];

endmodule

// File: rtl/fbp_divisor_hold.sv
`timescale 1ns/1ps
module fbp_divisor_hold #(
    parameter int FRAC_W = fbp_pkg::FRAC_W,
    parameter int DIV_W  = fbp_pkg::div_width(fbp_pkg::SEL_W, fbp_pkg::STEP_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             reload,
    input  logic [DIV_W-1:0] next_div,
    output logic [DIV_W-1:0] div_q
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1) << FRAC_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= ONE;
        end else if (!en || reload) begin
            div_q <= next_div;
        end
    end

endmodule

// File: rtl/fbp_phase_accum.sv
`timescale 1ns/1ps
module fbp_phase_accum #(
    parameter int FRAC_W = fbp_pkg::FRAC_W,
    parameter int DIV_W  = fbp_pkg::div_width(fbp_pkg::SEL_W, fbp_pkg::STEP_W),
    parameter int ACC_W  = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             hit,
    output logic [ACC_W-1:0] acc_q,
    output logic             tick_q
);
    localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] div_ext;
    logic [ACC_W-1:0] acc_d;

    assign div_ext = {{(ACC_W-DIV_W){1'b0}}, div};
    assign sum     = acc_q + ONE;
    assign hit     = en && (sum >= div_ext);

    always_comb begin
        if (!en) begin
            acc_d = '0;
        end else if (hit) begin
            acc_d = sum - div_ext;
        end else begin
            acc_d = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            tick_q <= hit;
        end
    end

endmodule

// File: rtl/frac_baud_prescaler.sv
`timescale 1ns/1ps
module frac_baud_prescaler #(
    parameter int SEL_W  = fbp_pkg::SEL_W,
    parameter int STEP_W = fbp_pkg::STEP_W,
    parameter int FRAC_W = fbp_pkg::FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [SEL_W-1:0]  range_sel,
    input  logic [STEP_W-1:0] step_val,
    output logic              tick
);
    localparam int DIV_W = fbp_pkg::div_width(SEL_W, STEP_W);
    localparam int ACC_W = DIV_W + 1;

    logic [DIV_W-1:0] next_div;
    logic [DIV_W-1:0] div_q;
    logic [ACC_W-1:0] acc_q;
    logic             hit;

    fbp_divisor_decode #(
        .SEL_W(SEL_W), .STEP_W(STEP_W), .FRAC_W(FRAC_W), .DIV_W(DIV_W)
    ) u_decode (
        .sel(range_sel),
        .step(step_val),
        .divisor(next_div)
    );

    fbp_divisor_hold #(
        .FRAC_W(FRAC_W), .DIV_W(DIV_W)
    ) u_hold (
        .clk(clk),
        .rst(rst),
        .en(en),
        .reload(hit),
        .next_div(next_div),
        .div_q(div_q)
    );

    fbp_phase_accum #(
        .FRAC_W(FRAC_W), .DIV_W(DIV_W), .ACC_W(ACC_W)
    ) u_accum (
        .clk(clk),
        .rst(rst),
        .en(en),
        .div(div_q),
        .hit(hit),
        .acc_q(acc_q),
        .tick_q(tick)
    );

endmodule

// File: rtl/fbp_checker.sv
`timescale 1ns/1ps
module fbp_checker #(
    parameter int FRAC_W = fbp_pkg::FRAC_W,
    parameter int DIV_W  = fbp_pkg::div_width(fbp_pkg::SEL_W, fbp_pkg::STEP_W),
    parameter int ACC_W  = DIV_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             tick,
    input logic [DIV_W-1:0] div_q,
    input logic [ACC_W-1:0] acc_q
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1) << FRAC_W;

    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    // R1: reset leaves tick low and phase cleared
    p_reset_quiet_r1: assert property (@(posedge clk)
        (armed && $past(rst)) |-> (!tick && acc_q == '0));

    // R7: an idle cycle emits nothing and clears the phase
    p_idle_no_tick_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!tick && acc_q == '0));

    // R3: divide-by-one fires on every enabled cycle
    p_div_one_every_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        (en && div_q == ONE) |=> tick);

    // R4: the phase never reaches the held divisor
    p_acc_below_div_r4: assert property (@(posedge clk) disable iff (rst)
        acc_q < {1'b0, div_q});

    // R8: the held divisor moves only at a tick or while idle
    p_div_held_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(en) && !tick) |-> $stable(div_q));

endmodule

bind frac_baud_prescaler fbp_checker #(
    .FRAC_W(FRAC_W), .DIV_W(DIV_W), .ACC_W(ACC_W)
) u_fbp_checker (
    .clk(clk),
    .rst(rst),
    .en(en),
    .tick(tick),
    .div_q(div_q),
    .acc_q(acc_q)
);

// File: tb/test_frac_baud_prescaler.sv
`timescale 1ns/1ps
module test_frac_baud_prescaler;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [2:0] range_sel = 3'd0;
    logic [7:0] step_val  = 8'd0;
    logic       tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    frac_baud_prescaler i_frac_baud_prescaler (
        .clk(clk), .rst(rst), .en(en),
        .range_sel(range_sel), .step_val(step_val), .tick(tick)
    );

    function automatic int div_of(input int s, input int st);
        if (s == 7) return 128;
        return (1 << (s + 8)) + st * (1 << s);
    endfunction

    function automatic bit exp_tick(input int c, input int d);
        return ((c * 128) / d) != (((c - 1) * 128) / d);
    endfunction

    task automatic check(input string req, input bit ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic go_idle(input int s, input int st);
        @(negedge clk);
        en = 1'b0; range_sel = 3'(s); step_val = 8'(st);
        @(negedge clk);
        check("R7 idle", tick == 1'b0, tick, 0);
        en = 1'b1;
    endtask

    // Runs ncyc enabled cycles and compares every cycle against R4; periods against R5.
    task automatic run_cfg(input int s, input int st, input int ncyc);
        int d, bad_c, bad_a, n_ticks, last, per_bad, per_val;
        d = div_of(s, st);
        bad_c = 0; bad_a = 0; n_ticks = 0; last = 0; per_bad = 0; per_val = 0;
        go_idle(s, st);
        for (int c = 1; c <= ncyc; c++) begin
            @(negedge clk);
            if (tick !== exp_tick(c, d) && bad_c == 0) begin
                bad_c = c; bad_a = tick;
            end
            if (tick === 1'b1) begin
                n_ticks++;
                if (((c - last) != d / 128) && ((c - last) != (d + 127) / 128) && per_bad == 0) begin
                    per_bad = 1; per_val = c - last;
                end
                last = c;
            end
        end
        en = 1'b0;
        if (s == 7) check("R3 divide-by-one pattern", bad_c == 0, bad_c, 0);
        else        check("R2 divisor/R4 tick timing", bad_c == 0, bad_c, 0);
        if (bad_c != 0) $display("    cfg sel=%0d step=%0d first bad cycle %0d tick=%0d", s, st, bad_c, bad_a);
        check("R5 period floor/ceil", per_bad == 0, per_val, d / 128);
        check("R4 tick count", n_ticks == (ncyc * 128) / d, n_ticks, (ncyc * 128) / d);
    endtask

    // R6: 128 ticks span exactly D/128*128 cycles
    task automatic run_full(input int s, input int st);
        int d, n_ticks, last;
        d = div_of(s, st);
        n_ticks = 0; last = 0;
        go_idle(s, st);
        for (int c = 1; c <= d; c++) begin
            @(negedge clk);
            if (tick === 1'b1) begin
                n_ticks++;
                last = c;
            end
        end
        en = 1'b0;
        check("R6 128 ticks count", n_ticks == 128, n_ticks, 128);
        check("R6 128th tick cycle", last == d, last, d);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        // R1: reset with enable high must hold the output quiet
        en = 1'b1; range_sel = 3'd7;
        repeat (4) @(negedge clk);
        check("R1 tick in reset", tick == 1'b0, tick, 0);
        rst = 1'b0; en = 1'b0;
        @(negedge clk);
        check("R1 tick after reset", tick == 1'b0, tick, 0);

        // R2/R4/R5 sweep over all bands
        for (int s = 0; s < 7; s++) begin
            run_cfg(s, 0, 600);
            run_cfg(s, 1, 600);
            run_cfg(s, 77, 600);
            run_cfg(s, 128, 600);
            run_cfg(s, 255, 600);
        end
        // R3: step ignored at divide-by-one
        run_cfg(7, 0, 64);
        run_cfg(7, 255, 64);

        // R6 full cycles
        run_full(0, 255);
        run_full(3, 7);
        run_full(6, 255);

        // R7: drop enable mid-run, then restart matches from edge 1
        go_idle(1, 3);
        for (int c = 1; c <= 37; c++) @(negedge clk);
        en = 1'b0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R7 no tick while idle", tick == 1'b0, tick, 0);
        end
        run_cfg(1, 3, 200);

        // R8: change band mid-period; old period (16 cycles) finishes first
        go_idle(3, 0);
        for (int c = 1; c <= 5; c++) @(negedge clk);
        range_sel = 3'd0; step_val = 8'd0;
        begin
            int first;
            first = 0;
            for (int c = 6; c <= 20; c++) begin
                @(negedge clk);
                if (tick === 1'b1 && first == 0) first = c;
                if (c == 18) check("R8 new divisor after boundary", tick == 1'b1, tick, 1);
                if (c == 19) check("R8 new period gap", tick == 1'b0, tick, 0);
                if (c == 20) check("R8 new period second tick", tick == 1'b1, tick, 1);
            end
            check("R8 old period kept", first == 16, first, 16);
        end
        en = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule